// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between a CPU and a cartridge ROM of up to 128 MB. It splits the low 4 MB of CPU address space into eight windows of 512 KB each. Window 0 always shows physical bank 0. Each of windows 1 to 7 shows the physical bank held in its own 8-bit bank register. The CPU writes the registers through a 256-byte window at 0xA13000. The block drives the physical ROM address for every CPU address it sees. It also tells the bus fabric when an access in the 0x200000–0x3FFFFF area must go to the save-RAM adapter instead of ROM.

Register 0 is not a bank register. It is a control register. Its bit 0 takes the upper four windows (4 to 7) off ROM and hands them to the save-RAM path. Its two low bits together decide whether save-RAM writes are allowed. Two rules apply to window state:
- Writing a bank register puts that one window back on ROM at once.
- Clearing bit 0 of register 0 puts all upper windows back on ROM, using the current contents of their bank registers.

Translation is combinational. A register write takes effect at the clock edge that samples it.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, bank register n holds n and register 0 holds 0. Every CPU address in the cartridge space therefore translates to itself. Save-RAM select and save-RAM write enable are both low.
- R2: A write is decoded only when wr_addr_i[23:8] equals 0xA130. Address bits 3:1 pick register 0 to 7. Writes outside this range change nothing.
- R3: A byte write (wr_word_i = 0) loads the register only when wr_addr_i[0] is 1, taking the value from wr_data_i[7:0]. A byte write at an even address is ignored.
- R4: A word write (wr_word_i = 1) loads the register from wr_data_i[7:0] whatever wr_addr_i[0] is. Bits 15:8 are ignored.
- R5: For window w in 1..7, where w is CPU address bits 21:19, rom_addr_o equals bank register w times 0x80000 plus CPU address bits 18:0.
- R6: Window 0 (CPU 0x000000–0x07FFFF) always gives physical bank 0, whatever is written to register 0.
- R7: After register 0 is written with bit 0 set, every access to 0x200000–0x3FFFFF (windows 4 to 7) raises sram_sel_o. Accesses below 0x200000 never raise it.
- R8: After register 0 is written with bit 0 clear, windows 4 to 7 show ROM again, each from its current bank register.
- R9: Writing bank register n (n ≠ 0) puts window n back on ROM immediately, even while bit 0 of register 0 is set. The other windows are untouched.
- R10: sram_wr_ok_o is 1 exactly when bits 1:0 of register 0 equal 01.
- R11: A write changes the outputs only from the cycle after the clock edge that samples it. A translation in the same cycle as the write uses the previous state.
- R12: CPU addresses with bits 23:22 non-zero never raise sram_sel_o. rom_addr_o is formed from CPU bits 21:0 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| wr_word_i | input | 1 | 1 = word write, 0 = byte write |
| wr_addr_i | input | 24 | CPU write byte address |
| wr_data_i | input | 16 | CPU write data |
| cpu_addr_i | input | 24 | CPU access address to translate |
| rom_addr_o | output | 27 | Physical ROM byte address |
| sram_sel_o | output | 1 | Access goes to the save-RAM path |
| sram_wr_ok_o | output | 1 | Save-RAM writes allowed |

## Verification
The main overlap is a register write in the same cycle as a translation that falls in the window being changed. Register 0 raises a similar case when its save-RAM toggle lands while the CPU is accessing 0x200000–0x3FFFFF. The bench drives both in one cycle and checks the outputs before the edge against the old mapping. It checks again one cycle later against the new mapping. A long mixed phase of random register writes, interleaved with random translations, repeats this against the behavioural model on every clock.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CART_AW = 22;  // 4 MB cartridge space
  localparam int TAG_LSB = 8;   // register window is 256 bytes
endpackage

// File: rtl/cbm_wr_decode.sv
module cbm_wr_decode #(
  parameter int AW     = 24,
  parameter int DW     = 16,
  parameter int BANK_W = 8,
  parameter int IDX_W  = 3,
  parameter logic [AW-cbm_pkg::TAG_LSB-1:0] REG_TAG = 'hA130
) (
  input  logic              wr_en_i,
  input  logic              wr_word_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              ld_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [BANK_W-1:0] val_o
);
  import cbm_pkg::*;

  logic hit;
  assign hit   = wr_addr_i[AW-1:TAG_LSB] == REG_TAG;
  // byte lanes: only odd byte reaches the 8-bit registers
  assign ld_o  = wr_en_i & hit & (wr_word_i | wr_addr_i[0]);
  assign idx_o = wr_addr_i[IDX_W:1];
  assign val_o = wr_data_i[BANK_W-1:0];

  logic unused_bits;
  assign unused_bits = ^{wr_addr_i[TAG_LSB-1:IDX_W+1], wr_data_i[DW-1:BANK_W]};
endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs #(
  parameter int NREG      = 8,
  parameter int BANK_W    = 8,
  parameter int SAVE_WIN0 = 4,
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ld_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [BANK_W-1:0]            val_i,
  output logic [NREG-1:0][BANK_W-1:0]  bank_o,
  output logic [NREG-1:0]              rom_on_o,
  output logic [BANK_W-1:0]            ctl_o
);
  logic ld_ctl;
  assign ld_ctl = ld_i && (idx_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_o <= '0;
    else if (ld_ctl) ctl_o <= val_i;
  end

  assign bank_o[0]   = '0;  // window 0 pinned to bank 0
  assign rom_on_o[0] = 1'b1;

  for (genvar n = 1; n < NREG; n++) begin : g_win
    logic ld_n;
    assign ld_n = ld_i && (idx_i == IDX_W'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bank_o[n] <= BANK_W'(n);
      else if (ld_n) bank_o[n] <= val_i;
    end

    if (n >= SAVE_WIN0) begin : g_save
      // per-window ROM enable: cleared together by ctl bit 0, restored singly
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     rom_on_o[n] <= 1'b1;
        else if (ld_n)   rom_on_o[n] <= 1'b1;
        else if (ld_ctl) rom_on_o[n] <= ~val_i[0];
      end
    end else begin : g_fixed
      assign rom_on_o[n] = 1'b1;
    end
  end
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate #(
  parameter int AW        = 24,
  parameter int NREG      = 8,
  parameter int BANK_W    = 8,
  parameter int SAVE_WIN0 = 4,
  localparam int WIN_W    = cbm_pkg::CART_AW - $clog2(NREG),
  localparam int PW       = BANK_W + WIN_W
) (
  input  logic [AW-1:0]                cpu_addr_i,
  input  logic [NREG-1:0][BANK_W-1:0]  bank_i,
  input  logic [NREG-1:0]              rom_on_i,
  input  logic [BANK_W-1:0]            ctl_i,
  output logic [PW-1:0]                rom_addr_o,
  output logic                         sram_sel_o,
  output logic                         sram_wr_ok_o
);
  import cbm_pkg::*;
  localparam int IDX_W = $clog2(NREG);

  logic [IDX_W-1:0] win;
  logic             in_cart, upper;

  assign win        = cpu_addr_i[CART_AW-1:WIN_W];
  assign in_cart    = cpu_addr_i[AW-1:CART_AW] == '0;
  assign upper      = win >= IDX_W'(SAVE_WIN0);
  assign rom_addr_o = {bank_i[win], cpu_addr_i[WIN_W-1:0]};
  assign sram_sel_o = in_cart & upper & ~rom_on_i[win];
  assign sram_wr_ok_o = ctl_i[1:0] == 2'b01;

  logic unused_ctl;
  assign unused_ctl = ^ctl_i[BANK_W-1:2];
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int NREG      = 8,
  parameter int BANK_W    = 8,
  parameter int SAVE_WIN0 = 4,
  localparam int IDX_W    = $clog2(NREG),
  localparam int PW       = BANK_W + cbm_pkg::CART_AW - IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_word_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic [PW-1:0] rom_addr_o,
  output logic          sram_sel_o,
  output logic          sram_wr_ok_o
);
  logic                        ld;
  logic [IDX_W-1:0]            idx;
  logic [BANK_W-1:0]           val;
  logic [NREG-1:0][BANK_W-1:0] bank;
  logic [NREG-1:0]             rom_on;
  logic [BANK_W-1:0]           ctl;

  cbm_wr_decode #(.AW(AW), .DW(DW), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_dec (
    .wr_en_i(wr_en_i), .wr_word_i(wr_word_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ld_o(ld), .idx_o(idx), .val_o(val)
  );

  cbm_bank_regs #(.NREG(NREG), .BANK_W(BANK_W), .SAVE_WIN0(SAVE_WIN0)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld), .idx_i(idx), .val_i(val),
    .bank_o(bank), .rom_on_o(rom_on), .ctl_o(ctl)
  );

  cbm_xlate #(.AW(AW), .NREG(NREG), .BANK_W(BANK_W), .SAVE_WIN0(SAVE_WIN0)) u_xl (
    .cpu_addr_i(cpu_addr_i), .bank_i(bank), .rom_on_i(rom_on), .ctl_i(ctl),
    .rom_addr_o(rom_addr_o), .sram_sel_o(sram_sel_o), .sram_wr_ok_o(sram_wr_ok_o)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_word_i,
  input logic [23:0] wr_addr_i,
  input logic [15:0] wr_data_i,
  input logic [23:0] cpu_addr_i,
  input logic [26:0] rom_addr_o,
  input logic        sram_sel_o,
  input logic        sram_wr_ok_o
);
  logic hit;
  assign hit = wr_en_i && (wr_addr_i[23:8] == 16'hA130);

  a_r6_win0_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[23:19] == 5'd0) |-> (rom_addr_o[26:19] == 8'd0));

  a_r12_no_sel_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[23:22] != 2'd0) |-> !sram_sel_o);

  a_r7_sel_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_sel_o |-> (cpu_addr_i[23:21] == 3'b001));

  a_r3_even_byte_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_word_i && !wr_addr_i[0]) ##1 $stable(cpu_addr_i) |->
      ($stable(rom_addr_o) && $stable(sram_sel_o) && $stable(sram_wr_ok_o)));

  a_r10_wr_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_word_i && wr_addr_i[3:1] == 3'd0) |=>
      (sram_wr_ok_o == ($past(wr_data_i[1:0]) == 2'b01)));

  a_r7_save_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_word_i && wr_addr_i[3:1] == 3'd0 && wr_data_i[0]) ##1
      (cpu_addr_i[23:21] == 3'b001) |-> sram_sel_o);

  a_r9_remap_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_word_i && wr_addr_i[3:1] != 3'd0) ##1
      (cpu_addr_i[23:22] == 2'd0 && cpu_addr_i[21:19] == $past(wr_addr_i[3:1])) |->
      (!sram_sel_o && rom_addr_o[26:19] == $past(wr_data_i[7:0])));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_word_i(wr_word_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cpu_addr_i(cpu_addr_i),
  .rom_addr_o(rom_addr_o), .sram_sel_o(sram_sel_o), .sram_wr_ok_o(sram_wr_ok_o)
);

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_word_i = 1'b0;
  logic [23:0] wr_addr_i = '0, cpu_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [26:0] rom_addr_o;
  logic        sram_sel_o, sram_wr_ok_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int mb[8];
  bit mv[8];
  int mctl;

  always #10 clk = ~clk;

  cart_bank_mapper u_cart_bank_mapper (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_word_i(wr_word_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cpu_addr_i(cpu_addr_i),
    .rom_addr_o(rom_addr_o), .sram_sel_o(sram_sel_o), .sram_wr_ok_o(sram_wr_ok_o)
  );

  task automatic model_reset();
    for (int n = 0; n < 8; n++) begin mb[n] = n; mv[n] = 1; end
    mctl = 0;
  endtask

  task automatic model_write(bit we, bit word, logic [23:0] a, logic [15:0] d);
    int idx, v;
    if (!we || a[23:8] != 16'hA130 || !(word || a[0])) return;
    idx = int'(a[3:1]);
    v = int'(d[7:0]);
    if (idx == 0) begin
      mctl = v;
      for (int w = 4; w < 8; w++) mv[w] = !d[0];
    end else begin
      mb[idx] = v;
      mv[idx] = 1;
    end
  endtask

  task automatic compare(string req);
    int win, bank;
    logic [26:0] e_rom;
    bit e_sel, e_ok;
    win  = int'(cpu_addr_i[21:19]);
    bank = (win == 0) ? 0 : mb[win];
    e_rom = 27'(bank) * 27'h80000 + 27'(cpu_addr_i[18:0]);
    e_sel = (cpu_addr_i[23:22] == 2'd0) && (win >= 4) && !mv[win];
    e_ok  = (mctl & 3) == 1;
    checks++;
    if (rom_addr_o !== e_rom || sram_sel_o !== e_sel || sram_wr_ok_o !== e_ok) begin
      fails++;
      $display("FAIL %s cpu=%h rom=%h/%h sel=%b/%b ok=%b/%b (actual/expected)",
               req, cpu_addr_i, rom_addr_o, e_rom, sram_sel_o, e_sel, sram_wr_ok_o, e_ok);
    end
  endtask

  task automatic cyc(bit we, bit word, logic [23:0] wa, logic [15:0] wd,
                     logic [23:0] ca, string req);
    @(negedge clk);
    wr_en_i = we; wr_word_i = word; wr_addr_i = wa; wr_data_i = wd; cpu_addr_i = ca;
    #2;
    compare(req);  // before the edge: old state (R11)
    @(posedge clk);
    model_write(we, word, wa, wd);
  endtask

  task automatic look(logic [23:0] ca, string req);
    cyc(1'b0, 1'b0, 24'h0, 16'h0, ca, req);
  endtask

  task automatic wrw(logic [23:0] wa, logic [15:0] wd, logic [23:0] ca, string req);
    cyc(1'b1, 1'b1, wa, wd, ca, req);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #2 compare("R1");
    rst_ni = 1'b1;
    // R1 identity after reset
    look(24'h000000, "R1"); look(24'h0ABCDE, "R1");
    look(24'h2F0001, "R1"); look(24'h3FFFFF, "R1");
    // R5 + R11: write window 5 while translating it
    wrw(24'hA1300A, 16'h0021, 24'h280010, "R11");
    look(24'h280010, "R5");
    look(24'h2FFFFF, "R5");
    // R3 byte lanes
    cyc(1'b1, 1'b0, 24'hA13004, 16'h0077, 24'h100000, "R3");
    look(24'h100000, "R3");
    cyc(1'b1, 1'b0, 24'hA13005, 16'h0033, 24'h100000, "R3");
    look(24'h100004, "R3");
    // R4 word writes ignore upper byte and address bit 0
    wrw(24'hA1300C, 16'hFF42, 24'h300000, "R4");
    look(24'h300000, "R4");
    wrw(24'hA1300F, 16'h0011, 24'h380000, "R4");
    look(24'h3ABCDE, "R4");
    // R2 window decode
    wrw(24'hA13100, 16'h0055, 24'h080000, "R2");
    wrw(24'hA12FFE, 16'h0055, 24'h080000, "R2");
    look(24'h080000, "R2");
    cyc(1'b1, 1'b0, 24'hA130F3, 16'h0066, 24'h080000, "R2");
    look(24'h080000, "R2");
    // R6 window 0 fixed
    wrw(24'hA13000, 16'h00FE, 24'h012345, "R6");
    look(24'h012345, "R6");
    look(24'h07FFFF, "R6");
    // R10 write-enable decode
    wrw(24'hA13000, 16'h0001, 24'h000100, "R10");
    look(24'h000100, "R10");
    wrw(24'hA13000, 16'h0003, 24'h000100, "R10");
    look(24'h000100, "R10");
    wrw(24'hA13000, 16'h0002, 24'h000100, "R10");
    look(24'h000100, "R10");
    // R7 save-RAM select, toggled while accessing the save area
    wrw(24'hA13000, 16'h0001, 24'h200000, "R11");
    look(24'h200000, "R7"); look(24'h27FFFF, "R7");
    look(24'h3FFFFF, "R7"); look(24'h1FFFFF, "R7");
    // R12 outside cartridge space
    look(24'h600000, "R12"); look(24'hA13000, "R12");
    // R9 single-window remap while disabled
    wrw(24'hA1300A, 16'h0010, 24'h280000, "R9");
    look(24'h280000, "R9");
    look(24'h300000, "R9");
    wrw(24'hA13008, 16'h0050, 24'h200000, "R9");
    // R8 restore all upper windows from current registers
    wrw(24'hA13000, 16'h0000, 24'h380000, "R11");
    look(24'h200000, "R8"); look(24'h280000, "R8");
    look(24'h300000, "R8"); look(24'h380000, "R8");
    // mixed random traffic, compared every cycle
    for (int i = 0; i < 600; i++) begin
      logic [23:0] wa, ca;
      wa = ($urandom % 4 == 0) ? 24'($urandom) : {16'hA130, 8'($urandom)};
      ca = ($urandom % 4 == 0) ? 24'($urandom) : {2'b00, 22'($urandom)};
      cyc(($urandom % 3) == 0, 1'($urandom), wa, 16'($urandom), ca, "R11");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule